// File: doc/BRIEF.md
# Streaming Prefetch Engine with Side Line Buffer

This per-core engine turns a recorded sequence of miss addresses into prefetch reads. A history reader delivers predicted addresses, and the engine puts them in a first-in first-out address queue. It sends one memory read per queued address, strictly in queue order. The returned lines go into a small fully associative side buffer, not into the cache, so a wrong prediction never displaces useful cache contents.

The core sends each demand request to the engine first. A demand that matches a buffered line is answered with that line's data, and the entry is released. A demand that matches a line still on its way from memory is held until the data arrives. A demand that matches nothing is answered as a miss.

Whenever the queue runs low, the engine asks the history reader for another batch of addresses. As demand hits drain the buffer and the queue, the stream therefore keeps advancing. Starting a new stream discards the queued addresses and any refill still in progress, but keeps the lines already held in the buffer.

Top module: `stp_stream_engine`

## Requirements
- R1: After reset, `refill_req`, `mem_req_valid` and `dmd_resp_valid` are low. No refill is requested until the first `stream_start`.
- R2: A `stream_start` in cycle k yields a one-cycle `refill_req` pulse after the edge of cycle k+1. While a refill is outstanding, no further pulse is raised. A refill stops being outstanding after REFILL_N addresses have been received, and another pulse then follows while the queue holds LOW_MARK or fewer entries. A new `stream_start` cancels an outstanding refill and leads to a fresh pulse.
- R3: Prefetch reads leave on `mem_req_addr` in exactly the order the addresses were accepted, one read per address. A request stays stable until `mem_req_ready` is seen.
- R4: The queue holds AQ_DEPTH addresses. An address that arrives while the queue is full is discarded and never read.
- R5: A demand on a buffered, filled line gives `dmd_resp_valid` with `dmd_resp_hit`=1 and that line's data. The line is then released, so a repeat demand for the same address is a miss.
- R6: A demand on an address that is neither buffered nor in flight gives `dmd_resp_hit`=0.
- R7: A demand on a line whose read is still in flight produces no response until the data returns. It then responds as a hit with the returned data.
- R8: An address that is already buffered or in flight is dropped from the queue, and no second read is issued for it.
- R9: If no buffer entry is free, the new read replaces the filled line that was allocated earliest. Lines still in flight are never replaced.
- R10: `stream_start` flushes all queued addresses, so none of them is read. Lines already in the buffer stay available to demands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_start | input | 1 | Begin a new stream: flush the queue, cancel the refill |
| hist_valid | input | 1 | Address from the history reader is valid |
| hist_addr | input | AW | Predicted line address |
| refill_req | output | 1 | One-cycle request for the next batch of addresses |
| mem_req_valid | output | 1 | Prefetch read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Prefetch read address |
| mem_req_tag | output | TW | Buffer entry that the read fills |
| mem_rsp_valid | input | 1 | Read data return valid |
| mem_rsp_tag | input | TW | Buffer entry being filled |
| mem_rsp_data | input | DW | Returned line data |
| dmd_valid | input | 1 | Core demand lookup, one cycle; ignored while a demand is unresolved |
| dmd_addr | input | AW | Demand address |
| dmd_resp_valid | output | 1 | Demand result valid, one cycle |
| dmd_resp_hit | output | 1 | Demand was served from the buffer |
| dmd_resp_data | output | DW | Line data on a hit |

## Verification
The bench builds the engine with its default parameters: a 16-entry queue, an 8-line buffer, and refill batches of 8 with a low mark of 8. A burst of 20 addresses against a stalled memory port therefore overfills the queue by a known amount. Nine distinct addresses are enough to fill the buffer and force a replacement, so the choice of victim can be observed through later demands. A response hold in the bench memory model keeps a line in flight for as long as needed, which exposes the waiting demand and duplicate suppression against an unfilled entry.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic {
    DMD_IDLE,
    DMD_LOOKUP
  } dmd_state_e;

  function automatic int wrap_inc(input int v, input int depth);
    return (v == depth - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/stp_addr_fifo.sv
module stp_addr_fifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic          head_valid,
  output logic [AW-1:0] head_addr,
  output logic [CW-1:0] count
);
  import stp_pkg::*;

  logic [AW-1:0] store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_pop, do_push;

  assign do_pop     = pop && (count != '0);
  assign do_push    = push && ((count != CW'(DEPTH)) || do_pop);
  assign head_valid = (count != '0);
  assign head_addr  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) store[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && push && !pop && !flush) |=> count == CW'(DEPTH));

endmodule

// File: rtl/stp_line_buf.sv
module stp_line_buf #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] q_addr,
  output logic          q_hit,
  input  logic [AW-1:0] d_addr,
  output logic          d_match,
  output logic          d_ready,
  output logic [IW-1:0] d_idx,
  output logic [DW-1:0] d_data,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  output logic          victim_ok,
  output logic [IW-1:0] victim_idx,
  input  logic          alloc_en,
  input  logic [AW-1:0] alloc_addr,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data
);
  logic [N-1:0]  valid, pend;
  logic [AW-1:0] tag   [N];
  logic [DW-1:0] lines [N];
  logic [N-1:0]  older [N];   // older[i][j]: entry i allocated before entry j
  logic [N-1:0]  qmv, dmv, cand, excl;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign qmv[g] = valid[g] && (tag[g] == q_addr);
    assign dmv[g] = valid[g] && (tag[g] == d_addr);
  end

  assign q_hit   = |qmv;
  assign d_match = |dmv;
  assign d_ready = d_match && !pend[d_idx];
  assign d_data  = lines[d_idx];

  always_comb begin
    d_idx = '0;
    for (int i = 0; i < N; i++) if (dmv[i]) d_idx = IW'(i);
  end

  always_comb begin
    excl       = free_en ? (N'(1) << free_idx) : '0;
    cand       = valid & ~pend & ~excl;
    victim_ok  = 1'b0;
    victim_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (&(older[i] | ~cand | (N'(1) << i)))) begin
        victim_ok  = 1'b1;
        victim_idx = IW'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim_ok  = 1'b1;
        victim_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag[victim_idx] <= alloc_addr;
    if (fill_en)  lines[fill_idx] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      pend  <= '0;
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      if (free_en) valid[free_idx] <= 1'b0;
      if (fill_en) pend[fill_idx]  <= 1'b0;
      if (alloc_en) begin
        valid[victim_idx] <= 1'b1;
        pend[victim_idx]  <= 1'b1;
        for (int j = 0; j < N; j++) older[j][victim_idx] <= 1'b1;
        older[victim_idx] <= '0;
      end
    end
  end

  // R8
  uniq_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dmv));

  // R7
  fill_pending_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> (valid[fill_idx] && pend[fill_idx]));

endmodule

// File: rtl/stp_stream_engine.sv
module stp_stream_engine #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int AQ_DEPTH = 16,
  parameter int PB_LINES = 8,
  parameter int REFILL_N = 8,
  parameter int LOW_MARK = 8,
  localparam int TW = (PB_LINES > 1) ? $clog2(PB_LINES) : 1,
  localparam int CW = $clog2(AQ_DEPTH + 1),
  localparam int RW = $clog2(REFILL_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stream_start,
  input  logic          hist_valid,
  input  logic [AW-1:0] hist_addr,
  output logic          refill_req,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_rsp_valid,
  input  logic [TW-1:0] mem_rsp_tag,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          dmd_valid,
  input  logic [AW-1:0] dmd_addr,
  output logic          dmd_resp_valid,
  output logic          dmd_resp_hit,
  output logic [DW-1:0] dmd_resp_data
);
  import stp_pkg::*;

  logic          head_valid, q_hit, can_issue, issue, dup_drop;
  logic [AW-1:0] head_addr;
  logic [CW-1:0] q_count;
  logic          d_match, d_ready, victim_ok;
  logic [TW-1:0] d_idx, victim_idx;
  logic [DW-1:0] d_data;
  logic          active, refill_out;
  logic [RW-1:0] rx_cnt;
  dmd_state_e    dmd_state;
  logic [AW-1:0] dmd_addr_q;
  logic          resolve_hit, resolve_miss;

  assign can_issue = !mem_req_valid || mem_req_ready;
  assign dup_drop  = head_valid && q_hit && !stream_start;
  assign issue     = head_valid && !q_hit && can_issue && victim_ok && !stream_start;

  stp_addr_fifo #(.AW(AW), .DEPTH(AQ_DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .flush      (stream_start),
    .push       (hist_valid),
    .push_addr  (hist_addr),
    .pop        (issue || dup_drop),
    .head_valid (head_valid),
    .head_addr  (head_addr),
    .count      (q_count)
  );

  assign resolve_hit  = (dmd_state == DMD_LOOKUP) && d_ready;
  assign resolve_miss = (dmd_state == DMD_LOOKUP) && !d_match;

  stp_line_buf #(.AW(AW), .DW(DW), .N(PB_LINES)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .q_addr     (head_addr),
    .q_hit      (q_hit),
    .d_addr     (dmd_addr_q),
    .d_match    (d_match),
    .d_ready    (d_ready),
    .d_idx      (d_idx),
    .d_data     (d_data),
    .free_en    (resolve_hit),
    .free_idx   (d_idx),
    .victim_ok  (victim_ok),
    .victim_idx (victim_idx),
    .alloc_en   (issue),
    .alloc_addr (head_addr),
    .fill_en    (mem_rsp_valid),
    .fill_idx   (mem_rsp_tag),
    .fill_data  (mem_rsp_data)
  );

  // Prefetch read request register
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_tag   <= '0;
    end else if (issue) begin
      mem_req_valid <= 1'b1;
      mem_req_addr  <= head_addr;
      mem_req_tag   <= victim_idx;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  // Refill request toward the history reader
  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      refill_out <= 1'b0;
      refill_req <= 1'b0;
      rx_cnt     <= '0;
    end else if (stream_start) begin
      active     <= 1'b1;
      refill_out <= 1'b0;
      refill_req <= 1'b0;
      rx_cnt     <= '0;
    end else begin
      refill_req <= 1'b0;
      if (refill_out) begin
        if (hist_valid) begin
          if (rx_cnt == RW'(REFILL_N - 1)) begin
            refill_out <= 1'b0;
            rx_cnt     <= '0;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        end
      end else if (active && (q_count <= CW'(LOW_MARK))) begin
        refill_req <= 1'b1;
        refill_out <= 1'b1;
        rx_cnt     <= '0;
      end
    end
  end

  // Demand lookup
  always_ff @(posedge clk) begin
    if (rst) begin
      dmd_state      <= DMD_IDLE;
      dmd_addr_q     <= '0;
      dmd_resp_valid <= 1'b0;
      dmd_resp_hit   <= 1'b0;
      dmd_resp_data  <= '0;
    end else begin
      dmd_resp_valid <= 1'b0;
      if (dmd_state == DMD_LOOKUP) begin
        if (resolve_hit || resolve_miss) begin
          dmd_state      <= DMD_IDLE;
          dmd_resp_valid <= 1'b1;
          dmd_resp_hit   <= resolve_hit;
          dmd_resp_data  <= resolve_hit ? d_data : '0;
        end
      end else if (dmd_valid) begin
        dmd_state  <= DMD_LOOKUP;
        dmd_addr_q <= dmd_addr;
      end
    end
  end

  // R2
  refill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |=> !refill_req);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag)));

  // R7
  inflight_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((dmd_state == DMD_LOOKUP) && d_match && !d_ready) |=> !dmd_resp_valid);

  // R5
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmd_resp_valid |=> !dmd_resp_valid);

endmodule

// File: tb/tb_stp_stream_engine.sv
module tb_stp_stream_engine;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int TW = 3;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stream_start = 1'b0;
  logic          hist_valid = 1'b0;
  logic [AW-1:0] hist_addr = '0;
  logic          refill_req;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic          mem_rsp_valid;
  logic [TW-1:0] mem_rsp_tag;
  logic [DW-1:0] mem_rsp_data;
  logic          dmd_valid = 1'b0;
  logic [AW-1:0] dmd_addr = '0;
  logic          dmd_resp_valid;
  logic          dmd_resp_hit;
  logic [DW-1:0] dmd_resp_data;

  stp_stream_engine dut (
    .clk            (clk),
    .rst            (rst),
    .stream_start   (stream_start),
    .hist_valid     (hist_valid),
    .hist_addr      (hist_addr),
    .refill_req     (refill_req),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_tag    (mem_req_tag),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_tag    (mem_rsp_tag),
    .mem_rsp_data   (mem_rsp_data),
    .dmd_valid      (dmd_valid),
    .dmd_addr       (dmd_addr),
    .dmd_resp_valid (dmd_resp_valid),
    .dmd_resp_hit   (dmd_resp_hit),
    .dmd_resp_data  (dmd_resp_data)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int refill_pulses = 0;
  int resp_cnt = 0;
  logic          last_hit;
  logic [DW-1:0] last_data;
  logic          mem_hold = 1'b0;
  logic [AW-1:0] log_a [256];
  int            log_n = 0;
  logic [AW-1:0] mq_addr [64];
  logic [TW-1:0] mq_tag [64];
  int            mq_due [64];
  int            mq_rd = 0;
  int            mq_wr = 0;

  function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [AW-1:0] addr_of(input int fam, input int i);
    return (AW'(fam) << 24) + AW'(i) * 32'h0000_1e40;
  endfunction

  // Memory model and issue log
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_tag   = '0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      #2;
      cyc++;
      mem_rsp_valid = 1'b0;
      if (!mem_hold && mq_rd != mq_wr && mq_due[mq_rd % 64] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = mq_tag[mq_rd % 64];
        mem_rsp_data  = fdata(mq_addr[mq_rd % 64]);
        mq_rd++;
      end
      if (mem_req_valid && mem_req_ready) begin
        mq_addr[mq_wr % 64] = mem_req_addr;
        mq_tag[mq_wr % 64]  = mem_req_tag;
        mq_due[mq_wr % 64]  = cyc + LAT;
        mq_wr++;
        if (log_n < 256) log_a[log_n] = mem_req_addr;
        log_n++;
      end
    end
  end

  // Output monitors
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (refill_req) refill_pulses++;
      if (dmd_resp_valid) begin
        resp_cnt++;
        last_hit  = dmd_resp_hit;
        last_data = dmd_resp_data;
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_addrs(input int fam, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      hist_valid = 1'b1;
      hist_addr  = addr_of(fam, i);
      step(1);
    end
    hist_valid = 1'b0;
  endtask

  task automatic pulse_start();
    stream_start = 1'b1;
    step(1);
    stream_start = 1'b0;
  endtask

  task automatic send_demand(input logic [AW-1:0] a);
    dmd_valid = 1'b1;
    dmd_addr  = a;
    step(1);
    dmd_valid = 1'b0;
  endtask

  task automatic demand(input logic [AW-1:0] a, output logic hit, output logic [DW-1:0] data);
    int c0;
    c0 = resp_cnt;
    send_demand(a);
    for (int k = 0; k < 30; k++) begin
      if (resp_cnt != c0) break;
      step(1);
    end
    hit  = (resp_cnt != c0) ? last_hit : 1'bx;
    data = last_data;
  endtask

  task automatic t_reset();
    check(refill_req == 1'b0, "R1 refill_req", 64'(refill_req), 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 0);
    check(dmd_resp_valid == 1'b0, "R1 dmd_resp_valid", 64'(dmd_resp_valid), 0);
    step(6);
    check(refill_pulses == 0, "R1 no refill before start", 64'(refill_pulses), 0);
  endtask

  task automatic t_stream();
    int n0;
    bit ok;
    n0 = log_n;
    pulse_start();
    step(6);
    check(refill_pulses == 1, "R2 single pulse", 64'(refill_pulses), 1);
    push_addrs(8'h40, 0, 8);
    step(20);
    check(log_n - n0 == 8, "R3 one read per address", 64'(log_n - n0), 8);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (log_a[n0 + i] != addr_of(8'h40, i)) ok = 1'b0;
    check(ok, "R3 issue order", 64'(ok), 1);
    check(refill_pulses == 2, "R2 next batch pulse", 64'(refill_pulses), 2);
  endtask

  task automatic t_hit();
    logic h;
    logic [DW-1:0] d;
    demand(addr_of(8'h40, 3), h, d);
    check(h === 1'b1, "R5 hit", 64'(h), 1);
    check(d == fdata(addr_of(8'h40, 3)), "R5 data", d, fdata(addr_of(8'h40, 3)));
    demand(addr_of(8'h40, 3), h, d);
    check(h === 1'b0, "R5 entry released", 64'(h), 0);
    demand(addr_of(8'hF0, 0), h, d);
    check(h === 1'b0, "R6 miss", 64'(h), 0);
  endtask

  task automatic t_dup();
    int n0;
    n0 = log_n;
    hist_valid = 1'b1;
    hist_addr  = addr_of(8'h40, 0);
    step(1);
    hist_addr  = addr_of(8'h50, 0);
    step(1);
    hist_valid = 1'b0;
    step(12);
    check(log_n == n0 + 1, "R8 buffered address dropped", 64'(log_n - n0), 1);
    check(log_a[n0] == addr_of(8'h50, 0), "R8 new address read", 64'(log_a[n0]),
          64'(addr_of(8'h50, 0)));
  endtask

  task automatic t_inflight();
    int n0;
    int c0;
    logic h;
    logic [DW-1:0] d;
    mem_hold = 1'b1;
    n0 = log_n;
    push_addrs(8'h60, 0, 1);
    step(4);
    check(log_n == n0 + 1 && log_a[n0] == addr_of(8'h60, 0), "R9 read issued with full buffer",
          64'(log_n - n0), 1);
    push_addrs(8'h60, 0, 1);
    step(3);
    check(log_n == n0 + 1, "R8 in-flight address dropped", 64'(log_n - n0), 1);
    c0 = resp_cnt;
    send_demand(addr_of(8'h60, 0));
    step(6);
    check(resp_cnt == c0, "R7 no early response", 64'(resp_cnt - c0), 0);
    mem_hold = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (resp_cnt != c0) break;
      step(1);
    end
    check(resp_cnt == c0 + 1 && last_hit == 1'b1 && last_data == fdata(addr_of(8'h60, 0)),
          "R7 hit after fill", last_data, fdata(addr_of(8'h60, 0)));
    demand(addr_of(8'h40, 0), h, d);
    check(h === 1'b0, "R9 oldest line replaced", 64'(h), 0);
    demand(addr_of(8'h40, 1), h, d);
    check(h === 1'b1, "R9 younger line kept", 64'(h), 1);
  endtask

  task automatic t_flush();
    int n0;
    int p0;
    bit seen;
    logic h;
    logic [DW-1:0] d;
    mem_req_ready = 1'b0;
    n0 = log_n;
    p0 = refill_pulses;
    push_addrs(8'h70, 0, 3);
    step(1);
    pulse_start();
    step(1);
    mem_req_ready = 1'b1;
    step(15);
    seen = 1'b0;
    for (int i = n0; i < log_n; i++)
      if (log_a[i] == addr_of(8'h70, 1) || log_a[i] == addr_of(8'h70, 2)) seen = 1'b1;
    check(!seen && log_n == n0 + 1, "R10 queued addresses flushed", 64'(log_n - n0), 1);
    check(refill_pulses == p0 + 1, "R2 cancel and new pulse", 64'(refill_pulses - p0), 1);
    demand(addr_of(8'h40, 2), h, d);
    check(h === 1'b1, "R10 buffered line kept", 64'(h), 1);
  endtask

  task automatic t_full();
    int n0;
    bit ok;
    mem_req_ready = 1'b0;
    n0 = log_n;
    push_addrs(8'h80, 0, 20);
    step(2);
    mem_req_ready = 1'b1;
    step(150);
    check(log_n - n0 == 17, "R4 overflow discarded", 64'(log_n - n0), 17);
    ok = 1'b1;
    for (int i = 0; i < 17; i++) if (log_a[n0 + i] != addr_of(8'h80, i)) ok = 1'b0;
    check(ok, "R4 kept addresses in order", 64'(ok), 1);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    t_reset();
    t_stream();
    t_hit();
    t_dup();
    t_inflight();
    t_flush();
    t_full();
    finish_run();
  end

endmodule